// File: doc/BRIEF.md
# PTP Clock Increment Calculator

This block works out the value a fixed-point time-of-day counter adds to itself on every cycle of its functional clock. The increment is a 64-bit word in 32.32 format: whole nanoseconds in the upper half and binary fractions of a nanosecond in the lower half. The functional clock rate comes from a small multiplier field applied to a 50 MHz reference. A signed fine-frequency correction then trims the nominal increment so that the counter can be steered faster or slower.

A single-cycle start pulse takes a snapshot of the multiplier, its valid flag and the correction. First the nominal increment is found by dividing one second, shifted left by 32 bits, by the clock rate. The block then scales that increment by the correction magnitude and removes the 16 fraction bits with a shift. A divide by one million turns the result into an adjustment. The adjustment is added for a positive correction and subtracted for a negative one. Both divides share one restoring divider that yields one quotient bit per cycle. The answer appears together with a one-cycle done pulse and holds until the next calculation completes.

Top module: `ptp_inc_calc`

## Requirements
- R1: While reset is asserted and after it is released, with no start given, busy_o and done_o are 0 and result_o is 0.
- R2: With mult_valid_i high and mult_i (6-bit unsigned) nonzero, the rate is 50,000,000 × mult_i Hz. The nominal increment is floor(10^9 × 2^32 / rate) in 64-bit unsigned arithmetic. A zero correction returns exactly that increment.
- R3: With mult_valid_i low, the multiplier is taken as 16 whatever mult_i holds.
- R4: With mult_valid_i high and mult_i equal to 0, the multiplier is taken as 16.
- R5: ppm_i is a two's complement number in parts per million with 16 fraction bits. For ppm_i ≥ 0 the result is nominal + adj, where adj = floor(floor(P / 2^16) / 10^6) and P = (nominal × |ppm_i|) mod 2^64.
- R6: For ppm_i < 0 the result is (nominal − adj) mod 2^64, with adj computed from the magnitude as in R5. A correction whose magnitude is below one scaled step gives adj = 0.
- R7: The product nominal × |ppm_i| keeps only its low 64 bits before the shift, even when the true product is wider.
- R8: done_o is high for exactly one cycle. It rises 2 × 64 + 4 = 132 clock edges after the edge that samples start_i while idle. busy_o is high from the accepting edge until done_o rises.
- R9: While busy_o is high, a start pulse and changes to mult_valid_i, mult_i and ppm_i are ignored. The running calculation keeps its result and timing, and no extra done_o follows.
- R10: result_o changes only in the cycle in which done_o is high. It holds its value while idle and throughout the next calculation.
- R11: Correction magnitudes up to 10^6 ppm (65,536,000,000 scaled) give the R5 and R6 result for both signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mult_valid_i | input | 1 | Multiplier field is valid |
| mult_i | input | MULT_W (6) | Clock rate multiplier of the 50 MHz reference |
| ppm_i | input | PPM_W (40) | Signed correction, ppm with 16 fraction bits |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | ACC_W (64) | Per-cycle increment, 32.32 nanoseconds |

## Verification
Zero corrections at several multipliers isolate the nominal-increment divide from the rest of the path. Invalid and zero multipliers show that both fallbacks land on the same rate of 16. Positive and negative corrections that differ only in sign separate the add path from the subtract path. A sub-step negative value shows the truncation to a zero adjustment. Full-scale corrections at low and high multipliers force the product past 64 bits, so a design that keeps a wider product gives a different answer. A second start with new operands in the middle of a calculation tells an ignored request apart from a restarted or corrupted one.

// File: rtl/ptp_inc_pkg.sv
`timescale 1ns/1ps
package ptp_inc_pkg;
  localparam logic [31:0] REF_HZ       = 32'd50_000_000;
  localparam int          FALLBACK_MUL = 16;
  localparam logic [63:0] NS_PER_SEC   = 64'd1_000_000_000;
  localparam logic [63:0] MILLION      = 64'd1_000_000;
  localparam int          CORR_FRAC    = 16;
  localparam int          NS_FRAC      = 32;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_NOM_GO,
    CS_NOM_WAIT,
    CS_ADJ_GO,
    CS_ADJ_WAIT
  } calc_state_t;
endpackage

// File: rtl/ptp_rate_sel.sv
`timescale 1ns/1ps
module ptp_rate_sel #(
  parameter int MULT_W = 6,
  parameter int RATE_W = 32
) (
  input  logic              valid_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic [RATE_W-1:0] rate_o
);
  import ptp_inc_pkg::*;

  logic              use_field;
  logic [MULT_W-1:0] eff_mult;

  always_comb begin
    use_field = valid_i && (mult_i != '0);
    eff_mult  = use_field ? mult_i : MULT_W'(FALLBACK_MUL);
    rate_o    = RATE_W'(REF_HZ) * RATE_W'(eff_mult);
  end
endmodule

// File: rtl/ptp_sign_split.sv
`timescale 1ns/1ps
module ptp_sign_split #(
  parameter int W = 40
) (
  input  logic signed [W-1:0] val_i,
  output logic [W-1:0]        mag_o,
  output logic                neg_o
);
  always_comb begin
    neg_o = val_i[W-1];
    mag_o = neg_o ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/ptp_seq_div.sv
`timescale 1ns/1ps
module ptp_seq_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             step_en;
  logic [W:0]       shifted;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    step_en = start_i || (cnt_q != '0);
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[W];

    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start_i) begin
      rem_d = '0;
      quo_d = dividend_i;
      dvs_d = divisor_i;
      cnt_d = CNT_W'(W);
    end else if (cnt_q != '0) begin
      rem_d  = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d  = {quo_q[W-2:0], fits};
      cnt_d  = cnt_q - CNT_W'(1);
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        dvs_q <= dvs_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/ptp_inc_calc.sv
`timescale 1ns/1ps
module ptp_inc_calc #(
  parameter int MULT_W = 6,
  parameter int PPM_W  = 40,
  parameter int ACC_W  = 64,
  parameter int RATE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    mult_valid_i,
  input  logic [MULT_W-1:0]       mult_i,
  input  logic signed [PPM_W-1:0] ppm_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [ACC_W-1:0]        result_o
);
  import ptp_inc_pkg::*;

  localparam logic [ACC_W-1:0] ONE_SEC_FX = ACC_W'(NS_PER_SEC << NS_FRAC);
  localparam logic [ACC_W-1:0] DIV_MILLION = ACC_W'(MILLION);

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  calc_state_t state_q, state_d;
  logic [RATE_W-1:0] rate_q;
  logic [PPM_W-1:0]  mag_q;
  logic              neg_q;
  logic [ACC_W-1:0]  nom_q, nom_d;
  logic [ACC_W-1:0]  res_q, res_d;
  logic              done_q, done_d;
  logic              snap_en, nom_en, res_en;

  logic [RATE_W-1:0] rate_w;
  logic [PPM_W-1:0]  mag_w;
  logic              neg_w;
  logic [ACC_W-1:0]  prod_w;

  logic              div_start, div_done;
  logic [ACC_W-1:0]  div_dvd, div_dvs, div_quot;

  ptp_rate_sel #(.MULT_W(MULT_W), .RATE_W(RATE_W)) u_rate (
    .valid_i (mult_valid_i),
    .mult_i  (mult_i),
    .rate_o  (rate_w)
  );

  ptp_sign_split #(.W(PPM_W)) u_sign (
    .val_i (ppm_i),
    .mag_o (mag_w),
    .neg_o (neg_w)
  );

  ptp_seq_div #(.W(ACC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (div_start),
    .dividend_i (div_dvd),
    .divisor_i  (div_dvs),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  // low ACC_W bits of nominal times magnitude
  assign prod_w = nom_q * ACC_W'(mag_q);

  always_comb begin
    state_d   = state_q;
    nom_d     = nom_q;
    res_d     = res_q;
    done_d    = 1'b0;
    snap_en   = 1'b0;
    nom_en    = 1'b0;
    res_en    = 1'b0;
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    case (state_q)
      CS_IDLE: begin
        if (start_i) begin
          snap_en = 1'b1;
          state_d = CS_NOM_GO;
        end
      end
      CS_NOM_GO: begin
        div_start = 1'b1;
        div_dvd   = ONE_SEC_FX;
        div_dvs   = ACC_W'(rate_q);
        state_d   = CS_NOM_WAIT;
      end
      CS_NOM_WAIT: begin
        if (div_done) begin
          nom_d   = div_quot;
          nom_en  = 1'b1;
          state_d = CS_ADJ_GO;
        end
      end
      CS_ADJ_GO: begin
        div_start = 1'b1;
        div_dvd   = prod_w >> CORR_FRAC;
        div_dvs   = DIV_MILLION;
        state_d   = CS_ADJ_WAIT;
      end
      CS_ADJ_WAIT: begin
        if (div_done) begin
          res_d   = neg_q ? (nom_q - div_quot) : (nom_q + div_quot);
          res_en  = 1'b1;
          done_d  = 1'b1;
          state_d = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= CS_IDLE;
      rate_q  <= '0;
      mag_q   <= '0;
      neg_q   <= 1'b0;
      nom_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (snap_en) begin
        rate_q <= rate_w;
        mag_q  <= mag_w;
        neg_q  <= neg_w;
      end
      if (nom_en) nom_q <= nom_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign busy_o   = (state_q != CS_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/ptp_inc_calc_chk.sv
`timescale 1ns/1ps
module ptp_inc_calc_chk #(
  parameter int ACC_W = 64,
  parameter int LAT   = 132
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ACC_W-1:0] result_o
);
  logic [15:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o)             lat_q <= lat_q + 16'd1;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == 16'(LAT))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R10
endmodule

bind ptp_inc_calc ptp_inc_calc_chk #(.ACC_W(ACC_W), .LAT(2 * ACC_W + 4)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/ptp_inc_calc_test.sv
`timescale 1ns/1ps
module ptp_inc_calc_test;
  localparam int LAT = 132;
  localparam logic signed [39:0] FULL = 40'sd65_536_000_000;

  logic                clk;
  logic                rst_n;
  logic                start_i;
  logic                mult_valid_i;
  logic [5:0]          mult_i;
  logic signed [39:0]  ppm_i;
  logic                busy_o;
  logic                done_o;
  logic [63:0]         result_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit ended = 0;

  logic [63:0] exp_q[$];
  int          launch_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;

  ptp_inc_calc uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_valid_i(mult_valid_i),
    .mult_i(mult_i), .ppm_i(ppm_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] model(input bit mv, input logic [5:0] m,
                                        input logic signed [39:0] p);
    logic [63:0] rate, nom, prod, adj;
    logic [39:0] mag;
    int unsigned me;
    me   = (mv && m != 0) ? int'(m) : 16;
    rate = 64'd50_000_000 * 64'(me);
    nom  = (64'd1_000_000_000 << 32) / rate;
    mag  = p[39] ? (~p + 40'd1) : p;
    prod = nom * 64'(mag);
    adj  = (prod >> 16) / 64'd1_000_000;
    return p[39] ? (nom - adj) : (nom + adj);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // driver: launch one calculation and post its expected outcome
  task automatic launch(input bit mv, input logic [5:0] m,
                        input logic signed [39:0] p, input string tag);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    mult_valid_i = mv;
    mult_i       = m;
    ppm_i        = p;
    start_i      = 1'b1;
    exp_q.push_back(model(mv, m, p));
    launch_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        int          l;
        string       t;
        e = exp_q.pop_front();
        l = launch_q.pop_front();
        t = tag_q.pop_front();
        check(result_o === e, t, "result", result_o, e);
        check((cyc - l) == LAT, "R8", "latency", 64'(cyc - l), 64'(LAT));
        last_exp = e;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !ended) begin
      check(1'b0, "WD", "watchdog expired", 64'(cyc), 64'd0);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mult_valid_i = 1'b0; mult_i = '0; ppm_i = '0;
    repeat (4) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1", "flags in reset",
          {62'd0, busy_o, done_o}, 64'd0);
    check(result_o === 64'd0, "R1", "result in reset", result_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && result_o === 64'd0, "R1",
          "idle after release", result_o, 64'd0);

    // R2: nominal increments with zero correction
    launch(1'b1, 6'd16, 40'sd0, "R2"); drain();
    check(last_exp == 64'd5_368_709_120, "R2", "model 800MHz", last_exp, 64'd5_368_709_120);
    launch(1'b1, 6'd20, 40'sd0, "R2"); drain();
    check(result_o == 64'h1_0000_0000, "R2", "1GHz is 1ns", result_o, 64'h1_0000_0000);
    launch(1'b1, 6'd63, 40'sd0, "R2"); drain();
    launch(1'b1, 6'd1, 40'sd0, "R2"); drain();

    // R3 / R4: multiplier fallbacks
    launch(1'b0, 6'd40, 40'sd0, "R3"); drain();
    check(result_o == 64'd5_368_709_120, "R3", "invalid field uses 16", result_o, 64'd5_368_709_120);
    launch(1'b1, 6'd0, 40'sd0, "R4"); drain();
    check(result_o == 64'd5_368_709_120, "R4", "zero field uses 16", result_o, 64'd5_368_709_120);

    // R5 / R6: signed corrections
    launch(1'b1, 6'd16, 40'sd6_553_600, "R5"); drain();
    launch(1'b1, 6'd16, -40'sd6_553_600, "R6"); drain();
    launch(1'b1, 6'd25, 40'sd123_456_789, "R5"); drain();
    launch(1'b1, 6'd25, -40'sd1, "R6"); drain();
    check(result_o == model(1'b1, 6'd25, 40'sd0), "R6", "sub-step negative", result_o,
          model(1'b1, 6'd25, 40'sd0));

    // R7 / R11: full-scale corrections overflow the product
    launch(1'b1, 6'd20, FULL, "R11"); drain();
    launch(1'b1, 6'd20, -FULL, "R11"); drain();
    launch(1'b1, 6'd1, FULL, "R7"); drain();
    launch(1'b1, 6'd63, -FULL, "R7"); drain();

    // R10: result holds while idle and during the next calculation
    repeat (20) @(negedge clk);
    check(result_o === last_exp, "R10", "hold while idle", result_o, last_exp);
    launch(1'b1, 6'd10, 40'sd65_536, "R10");
    repeat (50) @(negedge clk);
    check(result_o === last_exp, "R10", "hold while busy", result_o, last_exp);
    drain();

    // R9: start and new operands while busy are ignored
    launch(1'b1, 6'd32, -40'sd3_276_800, "R9");
    repeat (10) @(negedge clk);
    mult_valid_i = 1'b1; mult_i = 6'd3; ppm_i = FULL; start_i = 1'b1;
    repeat (2) @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R9", "still busy", {63'd0, busy_o}, 64'd1);
    drain();
    repeat (LAT + 10) @(negedge clk);
    check(busy_o === 1'b0, "R9", "no relaunch", {63'd0, busy_o}, 64'd0);
    check(result_o === last_exp, "R9", "result kept", result_o, last_exp);

    summary();
  end
endmodule